// File: doc/BRIEF.md
# Eight-Line Masked GPIO Controller with Pin Interrupts

This block drives and senses eight general purpose pins through a byte-wide register bus with a single write strobe and a combinational read port. Each pin is independently an input or an output. Data accesses fall in a window where byte-address bits [9:2] act as a per-pin mask. A write touches only the masked pins, and a read returns zero for pins outside the mask. Software can therefore change one pin, at address `1 << (n+2)`, without a read-modify-write sequence.

Every pin also has an interrupt detector. It passes the pin through a two-flop synchroniser and then classifies it in one of five trigger kinds: `TRIG_LOW` and `TRIG_HIGH` are level kinds, and `TRIG_FALL`, `TRIG_RISE` and `TRIG_ANY` are edge kinds. The kind is decoded from three configuration bits (sense, polarity, both-edges). It changes only when software rewrites those bits, so there are no autonomous transitions. Edge kinds latch a status bit until it is cleared by a write-one-to-clear. Level kinds report the live synchronised pin. Raw status is gated by an enable register, and the OR of the gated bits drives one interrupt line.

Register bank (byte offsets with bit 10 set): 0x400 direction, 0x404 interrupt enable, 0x408 sense, 0x40C polarity, 0x410 both-edges, 0x414 raw status (read-only), 0x418 masked status (read-only), 0x41C clear (write-only, reads zero).

Top module: `gpio8_ctrl`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` is 0, `pin_out` is 0 and `irq` is 0.
- R2: A write with address bit 10 clear updates the output latch only for pins whose bit in address[9:2] is 1 and whose direction bit is 1.
- R3: A read with address bit 10 clear returns 0 for unmasked pins. For masked pins it returns the output latch if the pin is an output, and the synchronised pin input if it is an input.
- R4: A direction bit of 1 makes that pin an output, so `pin_oe` equals the direction register.
- R5: A data write to a pin that is an input has no lasting effect. When the pin later becomes an output, it drives its old latch value until that value is written again.
- R6: With sense=1, raw status follows the synchronised pin: polarity=1 reports a high level and polarity=0 a low level. A clear write does not change it.
- R7: With sense=0 and both-edges=0, a rising edge (polarity=1) or a falling edge (polarity=0) sets a latched status bit, which stays set after the pin settles. Transitions of the other direction do not set it.
- R8: With sense=0 and both-edges=1, both transitions set the status bit, whatever the polarity bit holds.
- R9: Masked status equals raw status AND the enable register. `irq` is the OR of the masked bits, so an enable of 0 silences `irq`.
- R10: Writing 1s to the clear register clears only those latched edge bits. If an edge is detected in the same cycle as its clear, the bit stays set.
- R11: Direction, enable, sense, polarity and both-edges read back as written. Register accesses decode only at exact word offsets, and the clear register reads 0.
- R12: A pin change becomes visible to reads and level status two clock edges after it is applied, not one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 11 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Output latch values |
| pin_oe | output | 8 | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
The data window is tried with full masks, two-pin masks and single-pin masks, on a mix of output and input pins. This separates mask gating from direction gating and shows that writes to input pins are not stored. Interrupts are driven through each trigger kind. Rising and falling pins are placed opposite one another so that a wrong polarity sense shows up. A both-edges pin is set to the polarity that would reject one of its transitions. The clear is timed onto the exact cycle a new edge latches, which separates set-wins from clear-wins. The pin change is sampled one and two edges later, which exposes a missing or extra synchroniser stage.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;

    typedef enum logic [2:0] {
        SEL_DIR   = 3'd0,
        SEL_IEN   = 3'd1,
        SEL_SENSE = 3'd2,
        SEL_POL   = 3'd3,
        SEL_BOTH  = 3'd4,
        SEL_RAW   = 3'd5,
        SEL_MIS   = 3'd6,
        SEL_CLR   = 3'd7
    } reg_sel_t;

    typedef enum logic [2:0] {
        TRIG_LOW  = 3'd0,
        TRIG_HIGH = 3'd1,
        TRIG_FALL = 3'd2,
        TRIG_RISE = 3'd3,
        TRIG_ANY  = 3'd4
    } trig_kind_t;

    function automatic trig_kind_t trig_decode(input logic sense, input logic pol,
                                               input logic both);
        if (sense)
            return pol ? TRIG_HIGH : TRIG_LOW;
        else if (both)
            return TRIG_ANY;
        else
            return pol ? TRIG_RISE : TRIG_FALL;
    endfunction

endpackage

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio8_pin_irq.sv
module gpio8_pin_irq
    import gpio8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic sense,
    input  logic pol,
    input  logic both,
    input  logic clr,
    output logic raw
);
    trig_kind_t kind;
    logic       prev;
    logic       latched;
    logic       edge_hit;
    logic       lvl_hit;

    assign kind = trig_decode(sense, pol, both);

    always_comb begin
        edge_hit = 1'b0;
        lvl_hit  = 1'b0;
        unique case (kind)
            TRIG_LOW:  lvl_hit  = !pin_s;
            TRIG_HIGH: lvl_hit  = pin_s;
            TRIG_FALL: edge_hit = prev && !pin_s;
            TRIG_RISE: edge_hit = !prev && pin_s;
            TRIG_ANY:  edge_hit = prev ^ pin_s;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev    <= 1'b0;
            latched <= 1'b0;
        end else begin
            prev <= pin_s;
            if (edge_hit)
                latched <= 1'b1;
            else if (clr)
                latched <= 1'b0;
        end
    end

    assign raw = sense ? lvl_hit : latched;

    // R10: new edge wins over a simultaneous clear
    a_r10_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> latched);
    // R10: clear without a new edge drops the bit
    a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !edge_hit) |=> !latched);
    // R7: latched status only rises after a detected edge
    a_r7_rise_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latched) |-> $past(edge_hit));
endmodule

// File: rtl/gpio8_regfile.sv
module gpio8_regfile
    import gpio8_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = N + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [N-1:0]  wdata,
    input  logic [N-1:0]  pin_s,
    input  logic [N-1:0]  raw,
    output logic [N-1:0]  dir_q,
    output logic [N-1:0]  ien_q,
    output logic [N-1:0]  sense_q,
    output logic [N-1:0]  pol_q,
    output logic [N-1:0]  both_q,
    output logic [N-1:0]  out_q,
    output logic [N-1:0]  clr,
    output logic [N-1:0]  rdata
);
    localparam int BANK_BIT = N + 2;
    localparam int MASK_LSB = 2;
    localparam int MASK_MSB = N + 1;

    logic         data_win;
    logic         reg_hit;
    logic [N-1:0] mask;
    logic [N-1:0] wmask;
    logic [N-1:0] mis;
    reg_sel_t     sel;

    assign data_win = !addr[BANK_BIT];
    assign mask     = addr[MASK_MSB:MASK_LSB];
    assign sel      = reg_sel_t'(addr[4:2]);
    assign reg_hit  = !data_win && (addr[1:0] == 2'b00) && (addr[MASK_MSB:5] == '0);
    assign wmask    = mask & dir_q;
    assign mis      = raw & ien_q;
    assign clr      = (wr && reg_hit && sel == SEL_CLR) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            ien_q   <= '0;
            sense_q <= '0;
            pol_q   <= '0;
            both_q  <= '0;
            out_q   <= '0;
        end else if (wr) begin
            if (data_win) begin
                out_q <= (out_q & ~wmask) | (wdata & wmask);
            end else if (reg_hit) begin
                unique case (sel)
                    SEL_DIR:   dir_q   <= wdata;
                    SEL_IEN:   ien_q   <= wdata;
                    SEL_SENSE: sense_q <= wdata;
                    SEL_POL:   pol_q   <= wdata;
                    SEL_BOTH:  both_q  <= wdata;
                    SEL_RAW, SEL_MIS, SEL_CLR: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (data_win) begin
            rdata = mask & ((dir_q & out_q) | (~dir_q & pin_s));
        end else if (reg_hit) begin
            unique case (sel)
                SEL_DIR:   rdata = dir_q;
                SEL_IEN:   rdata = ien_q;
                SEL_SENSE: rdata = sense_q;
                SEL_POL:   rdata = pol_q;
                SEL_BOTH:  rdata = both_q;
                SEL_RAW:   rdata = raw;
                SEL_MIS:   rdata = mis;
                SEL_CLR:   rdata = '0;
            endcase
        end
    end

    // R5: data writes while all pins are inputs leave the latch alone
    a_r5_input_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && data_win && dir_q == '0) |=> $stable(out_q));
endmodule

// File: rtl/gpio8_ctrl.sv
module gpio8_ctrl
    import gpio8_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = N + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [N-1:0]  bus_wdata,
    output logic [N-1:0]  bus_rdata,
    input  logic [N-1:0]  pin_in,
    output logic [N-1:0]  pin_out,
    output logic [N-1:0]  pin_oe,
    output logic          irq
);
    logic [N-1:0] pin_s;
    logic [N-1:0] raw;
    logic [N-1:0] dir_q, ien_q, sense_q, pol_q, both_q, out_q, clr;

    gpio8_sync #(.W(N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    gpio8_regfile #(.N(N), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .pin_s   (pin_s),
        .raw     (raw),
        .dir_q   (dir_q),
        .ien_q   (ien_q),
        .sense_q (sense_q),
        .pol_q   (pol_q),
        .both_q  (both_q),
        .out_q   (out_q),
        .clr     (clr),
        .rdata   (bus_rdata)
    );

    for (genvar i = 0; i < N; i++) begin : g_pin
        gpio8_pin_irq u_irq (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_s (pin_s[i]),
            .sense (sense_q[i]),
            .pol   (pol_q[i]),
            .both  (both_q[i]),
            .clr   (clr[i]),
            .raw   (raw[i])
        );
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq     = |(raw & ien_q);

    // R9: with every pin masked the interrupt stays low
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);
    // R9: any interrupt implies an enabled raw bit
    a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((raw & ien_q) != '0));
endmodule

// File: tb/gpio8_ctrl_tb.sv
module gpio8_ctrl_tb;
    localparam logic [10:0] A_DATA  = 11'h3FC;
    localparam logic [10:0] A_DIR   = 11'h400;
    localparam logic [10:0] A_IEN   = 11'h404;
    localparam logic [10:0] A_SENSE = 11'h408;
    localparam logic [10:0] A_POL   = 11'h40C;
    localparam logic [10:0] A_BOTH  = 11'h410;
    localparam logic [10:0] A_RAW   = 11'h414;
    localparam logic [10:0] A_MIS   = 11'h418;
    localparam logic [10:0] A_CLR   = 11'h41C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    gpio8_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(A_DIR, v);   chk("R1 dir", v, 8'h00);
        rd(A_IEN, v);   chk("R1 ien", v, 8'h00);
        rd(A_SENSE, v); chk("R1 sense", v, 8'h00);
        rd(A_POL, v);   chk("R1 pol", v, 8'h00);
        rd(A_BOTH, v);  chk("R1 both", v, 8'h00);
        rd(A_RAW, v);   chk("R1 raw", v, 8'h00);
        rd(A_DATA, v);  chk("R1 data", v, 8'h00);
        chk("R1 oe", pin_oe, 8'h00);
        chk("R1 out", pin_out, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_masked_data();
        logic [7:0] v;
        wr(A_DIR, 8'h0F);
        chk("R4 oe follows dir", pin_oe, 8'h0F);
        wr(A_DATA, 8'hFF);
        chk("R2 only output pins", pin_out, 8'h0F);
        wr(11'h014, 8'h00);
        chk("R2 two-pin mask", pin_out, 8'h0A);
        wr(A_DIR, 8'hFF);
        chk("R5 input write not kept", pin_out, 8'h0A);
        wr(11'h3C0, 8'hF0);
        chk("R5 rewrite after switch", pin_out, 8'hFA);
        wr(A_DIR, 8'h0F);
        @(negedge clk); pin_in = 8'hA0;
        settle();
        rd(A_DATA, v);  chk("R3 mixed read", v, 8'hAA);
        rd(11'h080, v); chk("R3 single pin 5", v, 8'h20);
        rd(11'h040, v); chk("R3 single pin 4", v, 8'h00);
        rd(11'h008, v); chk("R3 output pin 1", v, 8'h02);
    endtask

    task automatic t_level();
        logic [7:0] v;
        wr(A_DIR, 8'h00);
        wr(A_SENSE, 8'h40);
        wr(A_POL, 8'h40);
        wr(A_IEN, 8'h40);
        rd(A_RAW, v); chk("R6 level high idle", v & 8'h40, 8'h00);
        pin_in = 8'hE0;
        @(negedge clk);
        rd(A_RAW, v); chk("R12 not after one edge", v & 8'h40, 8'h00);
        rd(11'h100, v); chk("R12 data not after one edge", v, 8'h00);
        @(negedge clk);
        rd(A_RAW, v); chk("R12 visible after two edges", v & 8'h40, 8'h40);
        chk("R9 irq on level", {7'b0, irq}, 8'h01);
        wr(A_CLR, 8'hFF);
        rd(A_RAW, v); chk("R6 clear ignored on level", v & 8'h40, 8'h40);
        wr(A_POL, 8'h00);
        rd(A_RAW, v); chk("R6 low polarity, pin high", v & 8'h40, 8'h00);
        @(negedge clk); pin_in = 8'hA0;
        settle();
        rd(A_RAW, v); chk("R6 low polarity, pin low", v & 8'h40, 8'h40);
        wr(A_SENSE, 8'h00);
        wr(A_IEN, 8'h00);
        wr(A_CLR, 8'hFF);
        rd(A_RAW, v); chk("R10 clear all", v, 8'h00);
    endtask

    task automatic t_edges();
        logic [7:0] v;
        wr(A_POL, 8'h02);
        wr(A_IEN, 8'h06);
        @(negedge clk); pin_in = 8'hA4;
        settle();
        rd(A_RAW, v); chk("R7 wrong directions ignored", v, 8'h00);
        chk("R9 irq idle", {7'b0, irq}, 8'h00);
        pin_in = 8'hA2;
        settle();
        rd(A_RAW, v); chk("R7 rise and fall latched", v, 8'h06);
        wr(A_IEN, 8'h02);
        rd(A_MIS, v); chk("R9 masked status", v, 8'h02);
        chk("R9 irq on enabled bit", {7'b0, irq}, 8'h01);
        wr(A_CLR, 8'h02);
        rd(A_RAW, v); chk("R10 selective clear", v, 8'h04);
        chk("R9 irq drops after clear", {7'b0, irq}, 8'h00);
        wr(A_IEN, 8'h00);
        rd(A_MIS, v); chk("R9 enable zero masks", v, 8'h00);
        settle();
        rd(A_RAW, v); chk("R7 latch holds", v, 8'h04);
        wr(A_CLR, 8'hFF);
        wr(A_POL, 8'h00);
    endtask

    task automatic t_both();
        logic [7:0] v;
        wr(A_BOTH, 8'h08);
        @(negedge clk); pin_in = 8'hAA;
        settle();
        rd(A_RAW, v); chk("R8 rise with pol=0", v, 8'h08);
        wr(A_CLR, 8'h08);
        rd(A_RAW, v); chk("R10 clear both-edge bit", v, 8'h00);
        @(negedge clk); pin_in = 8'hA2;
        settle();
        rd(A_RAW, v); chk("R8 fall", v, 8'h08);
        pin_in = 8'hAA;
        @(negedge clk);
        wr(A_CLR, 8'h08);
        rd(A_RAW, v); chk("R10 edge wins over clear", v, 8'h08);
        wr(A_CLR, 8'h08);
        rd(A_RAW, v); chk("R10 later clear works", v, 8'h00);
        wr(A_BOTH, 8'h00);
    endtask

    task automatic t_readback();
        logic [7:0] v;
        wr(A_DIR, 8'h5A);   rd(A_DIR, v);   chk("R11 dir", v, 8'h5A);
        wr(A_IEN, 8'h3C);   rd(A_IEN, v);   chk("R11 ien", v, 8'h3C);
        wr(A_SENSE, 8'h81); rd(A_SENSE, v); chk("R11 sense", v, 8'h81);
        wr(A_POL, 8'h7E);   rd(A_POL, v);   chk("R11 pol", v, 8'h7E);
        wr(A_BOTH, 8'h18);  rd(A_BOTH, v);  chk("R11 both", v, 8'h18);
        rd(A_CLR, v); chk("R11 clear reads zero", v, 8'h00);
        wr(11'h401, 8'hFF); rd(A_DIR, v); chk("R11 unaligned write ignored", v, 8'h5A);
        rd(11'h402, v); chk("R11 unaligned read zero", v, 8'h00);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked_data();
        t_level();
        t_edges();
        t_both();
        t_readback();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule